// File: doc/BRIEF.md
# SPI Serial Byte Memory Slave

This block is the slave side of a four-wire SPI link that gives a host access to a byte-wide register-file memory of 2048 locations. Every transaction begins when chip select falls. The first byte is a command. A memory command is followed by a two-byte address and then any number of data bytes. A status command is followed by one data byte. Writes take effect as soon as each byte arrives, so the host never polls for a ready flag. The internal address advances after each data byte, which allows long sequential transfers.

The block accepts both idle clock levels of SPI modes 0 and 3. It samples the data input on rising serial clock edges and changes its output on falling edges. A hold input can pause a transfer in the middle of a byte. The write-enable latch and the status register belong to a separate unit. This block tells that unit about decoded commands through single-cycle strobes. It receives back a write-permit level and the status byte that RDSR returns. All serial inputs pass through a synchronizer into the system clock domain.

Top module: `spi_mem_slave`

## Requirements
- R1: Command byte 0x06 produces exactly one single-cycle `cmd_wren` pulse and command byte 0x04 produces exactly one single-cycle `cmd_wrdi` pulse. At most one strobe among `cmd_wren`, `cmd_wrdi`, `sr_wr` and `wr_end` is high in any cycle.
- R2: Only the first byte after chip select falls is decoded as a command. An unknown command value, and any byte that follows a single-byte command, has no effect until chip select rises.
- R3: Bits are sampled on rising SCK edges, MSB first. A transaction that starts with SCK idle low (mode 0) and one that starts with SCK idle high (mode 3) behave the same.
- R4: READ (0x03) is followed by a 16-bit address, of which only the low 11 bits are used. The slave then returns the byte at that address MSB first on `spi_miso`, changing on falling SCK edges, and continues with the following addresses for as long as the host clocks. The address wraps from 0x7FF to 0x000.
- R5: WRITE (0x02) is followed by a 16-bit address and one or more data bytes. Each complete byte is stored at the current address, which then advances with the same wrap. A byte that is cut short by chip select rising is discarded.
- R6: If `wr_permit` is low when a WRITE or WRSR (0x01) command byte completes, the whole transaction is dropped. No memory byte changes and no `sr_wr` or `wr_end` pulse is issued.
- R7: RDSR (0x05) shifts out the value of `status_byte`, captured at the end of the command byte, and repeats a fresh capture for each following byte.
- R8: A permitted WRSR pulses `sr_wr` for one cycle once the next full byte has arrived, with that byte on `sr_data`. Any further bytes are ignored.
- R9: `spi_miso_oe` is high only while READ or RDSR data is being shifted out. It is low during command, address and write bytes, whenever chip select is high, and whenever hold is low.
- R10: While `spi_hold_n` is low, SCK and chip-select changes are ignored and the transfer state stays frozen. After release, the transfer continues from the same bit.
- R11: When chip select rises after a permitted WRITE or WRSR command, `wr_end` pulses for one cycle.
- R12: After reset `spi_miso_oe` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| wr_permit | input | 1 | Write permission from the status unit |
| status_byte | input | 8 | Status value returned by RDSR |
| cmd_wren | output | 1 | Write-enable command strobe |
| cmd_wrdi | output | 1 | Write-disable command strobe |
| sr_wr | output | 1 | Status-register write strobe |
| sr_data | output | 8 | Byte for the status-register write |
| wr_end | output | 1 | Permitted write transaction finished |

## Verification
A wrong phase or a wrong bit counter shows up within the next byte. Read data comes out shifted or from the wrong address, or the output enable rises during an address byte. A wrong address counter only shows up when data is read back, so the bench reads back every write, including runs that cross the top of the array. A hold that fails to freeze corrupts the byte in which the pause happened. A permit or strobe error changes the strobe counts that the bench checks right after chip select rises.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 11,
  parameter int SYNC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       spi_hold_n,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic       wr_permit,
  input  logic [7:0] status_byte,
  output logic       cmd_wren,
  output logic       cmd_wrdi,
  output logic       sr_wr,
  output logic [7:0] sr_data,
  output logic       wr_end
);
  localparam int DEPTH = 1 << ADDR_W;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_OP   = 3'd1;
  localparam logic [2:0] PH_AH   = 3'd2;
  localparam logic [2:0] PH_AL   = 3'd3;
  localparam logic [2:0] PH_DATA = 3'd4;
  localparam logic [2:0] PH_DONE = 3'd5;

  localparam logic [1:0] C_RD   = 2'd0;
  localparam logic [1:0] C_WR   = 2'd1;
  localparam logic [1:0] C_RDSR = 2'd2;
  localparam logic [1:0] C_WRSR = 2'd3;

  logic [SYNC-1:0] sck_sy, cs_sy, mosi_sy, hold_sy;
  logic sck_q, cs_q, mosi_q, hold_q;
  logic sck_p, cs_p;
  logic sck_rise, sck_fall;

  logic [2:0]        phase;
  logic [1:0]        cmd;
  logic [2:0]        bit_cnt;
  logic [6:0]        shreg;
  logic [7:0]        byte_in;
  logic [7:0]        tx;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_full;
  logic              miso_r, oe_r, wr_ok;
  logic              mem_we;
  logic              byte_done;
  logic              active;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      hold_sy <= '1;
    end else begin
      sck_sy  <= {sck_sy[SYNC-2:0],  spi_sck};
      cs_sy   <= {cs_sy[SYNC-2:0],   spi_cs_n};
      mosi_sy <= {mosi_sy[SYNC-2:0], spi_mosi};
      hold_sy <= {hold_sy[SYNC-2:0], spi_hold_n};
    end
  end

  assign sck_q  = sck_sy[SYNC-1];
  assign cs_q   = cs_sy[SYNC-1];
  assign mosi_q = mosi_sy[SYNC-1];
  assign hold_q = hold_sy[SYNC-1];

  assign sck_rise  = sck_q & ~sck_p;
  assign sck_fall  = ~sck_q & sck_p;
  assign byte_in   = {shreg, mosi_q};
  assign byte_done = bit_cnt == 3'd7;
  assign addr_full = {addr[ADDR_W-1:8], byte_in};
  assign active    = phase == PH_OP || phase == PH_AH || phase == PH_AL || phase == PH_DATA;

  assign mem_we = hold_q && !cs_q && !cs_p && sck_rise && byte_done &&
                  phase == PH_DATA && cmd == C_WR;

  assign spi_miso    = miso_r;
  assign spi_miso_oe = oe_r & hold_q & ~cs_q;

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= 1'b0;
      cs_p     <= 1'b1;
      phase    <= PH_IDLE;
      cmd      <= C_RD;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      addr     <= '0;
      miso_r   <= 1'b0;
      oe_r     <= 1'b0;
      wr_ok    <= 1'b0;
      cmd_wren <= 1'b0;
      cmd_wrdi <= 1'b0;
      sr_wr    <= 1'b0;
      sr_data  <= '0;
      wr_end   <= 1'b0;
    end else begin
      cmd_wren <= 1'b0;
      cmd_wrdi <= 1'b0;
      sr_wr    <= 1'b0;
      wr_end   <= 1'b0;
      if (hold_q) begin
        sck_p <= sck_q;
        cs_p  <= cs_q;
        if (cs_q) begin
          if (!cs_p && wr_ok) wr_end <= 1'b1;
          phase <= PH_IDLE;
          oe_r  <= 1'b0;
          wr_ok <= 1'b0;
        end else if (cs_p) begin
          phase   <= PH_OP;
          bit_cnt <= '0;
          oe_r    <= 1'b0;
          wr_ok   <= 1'b0;
        end else if (sck_rise && active) begin
          shreg   <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (byte_done) begin
            case (phase)
              PH_OP: begin
                case (byte_in)
                  OP_WREN: begin
                    cmd_wren <= 1'b1;
                    phase    <= PH_DONE;
                  end
                  OP_WRDI: begin
                    cmd_wrdi <= 1'b1;
                    phase    <= PH_DONE;
                  end
                  OP_RDSR: begin
                    cmd   <= C_RDSR;
                    tx    <= status_byte;
                    phase <= PH_DATA;
                  end
                  OP_WRSR: begin
                    cmd   <= C_WRSR;
                    wr_ok <= wr_permit;
                    phase <= wr_permit ? PH_DATA : PH_DONE;
                  end
                  OP_READ: begin
                    cmd   <= C_RD;
                    phase <= PH_AH;
                  end
                  OP_WRITE: begin
                    cmd   <= C_WR;
                    wr_ok <= wr_permit;
                    phase <= wr_permit ? PH_AH : PH_DONE;
                  end
                  default: phase <= PH_DONE;
                endcase
              end
              PH_AH: begin
                addr[ADDR_W-1:8] <= byte_in[ADDR_W-9:0];
                phase            <= PH_AL;
              end
              PH_AL: begin
                phase <= PH_DATA;
                if (cmd == C_RD) begin
                  tx   <= mem[addr_full];
                  addr <= addr_full + ADDR_W'(1);
                end else begin
                  addr <= addr_full;
                end
              end
              PH_DATA: begin
                case (cmd)
                  C_RD: begin
                    tx   <= mem[addr];
                    addr <= addr + ADDR_W'(1);
                  end
                  C_RDSR: tx <= status_byte;
                  C_WR:   addr <= addr + ADDR_W'(1);
                  default: begin
                    sr_wr   <= 1'b1;
                    sr_data <= byte_in;
                    phase   <= PH_DONE;
                  end
                endcase
              end
              default: phase <= PH_DONE;
            endcase
          end
        end else if (sck_fall && phase == PH_DATA && (cmd == C_RD || cmd == C_RDSR)) begin
          miso_r <= tx[7];
          tx     <= {tx[6:0], 1'b0};
          oe_r   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_q,
  input logic [2:0] phase,
  input logic [1:0] cmd,
  input logic [2:0] bit_cnt,
  input logic       wr_ok,
  input logic       mem_we,
  input logic       spi_miso_oe,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       sr_wr,
  input logic       wr_end
);
  localparam logic [2:0] K_OP   = 3'd1;
  localparam logic [2:0] K_DATA = 3'd4;
  localparam logic [2:0] K_DONE = 3'd5;
  localparam logic [2:0] K_IDLE = 3'd0;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, sr_wr, wr_end})); // R1
  AST_WREN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wren |=> !cmd_wren); // R1
  AST_WRDI_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrdi |-> $past(phase) == K_OP); // R1
  AST_ONE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    phase == K_DONE |=> (phase == K_DONE || phase == K_IDLE)); // R2
  AST_OE_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> (phase == K_DATA && (cmd == 2'd0 || cmd == 2'd2))); // R9
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> ($stable(phase) && $stable(bit_cnt))); // R10
  AST_WRITE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_ok); // R6
  AST_SR_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |-> wr_ok); // R6
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_q(hold_q), .phase(phase), .cmd(cmd),
  .bit_cnt(bit_cnt), .wr_ok(wr_ok), .mem_we(mem_we), .spi_miso_oe(spi_miso_oe),
  .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .sr_wr(sr_wr), .wr_end(wr_end)
);

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe, permit = 1'b0;
  logic [7:0] stat = 8'h00;
  logic wren, wrdi, srw, wend;
  logic [7:0] srd;

  int total = 0, bad = 0;
  int n_wren = 0, n_wrdi = 0, n_sr = 0, n_end = 0;
  logic [7:0] last_sr = 8'h00;
  logic m3 = 1'b0;
  logic oe_any, oe_all;
  logic [7:0] model [2048];

  always #5 clk = ~clk;

  spi_mem_slave i_spi_mem_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .wr_permit(permit), .status_byte(stat), .cmd_wren(wren), .cmd_wrdi(wrdi),
    .sr_wr(srw), .sr_data(srd), .wr_end(wend)
  );

  always @(negedge clk) begin
    if (wren) n_wren++;
    if (wrdi) n_wrdi++;
    if (srw) begin n_sr++; last_sr = srd; end
    if (wend) n_end++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] d, input int hi, input int lo, inout logic [7:0] r);
    for (int i = hi; i >= lo; i--) begin
      sck = 1'b0;
      mosi = d[i];
      wclk(HP);
      r[i] = miso;
      oe_any = oe_any | miso_oe;
      oe_all = oe_all & miso_oe;
      sck = 1'b1;
      wclk(HP);
    end
  endtask

  task automatic xb(input logic [7:0] d, output logic [7:0] r);
    logic [7:0] t = 8'h00;
    bits(d, 7, 0, t);
    r = t;
  endtask

  task automatic start();
    sck = m3;
    wclk(HP);
    cs_n = 1'b0;
    oe_any = 1'b0;
    wclk(HP);
  endtask

  task automatic stop();
    if (!m3) sck = 1'b0;
    wclk(HP);
    cs_n = 1'b1;
    wclk(3 * HP);
  endtask

  task automatic pause();
    sck = 1'b0;
    wclk(HP);
    hold_n = 1'b0;
    wclk(HP);
    chk(miso_oe == 1'b0, "R9 oe under hold", miso_oe, 0);
    sck = 1'b1; mosi = 1'b1; wclk(HP);
    cs_n = 1'b1; wclk(HP);
    sck = 1'b0; cs_n = 1'b0; wclk(HP);
    sck = 1'b1; wclk(HP);
    sck = 1'b0; wclk(HP);
    hold_n = 1'b1;
    wclk(HP);
  endtask

  task automatic wr_mem(input logic [15:0] a, input int n, input logic [7:0] d [8]);
    logic [7:0] r;
    start();
    xb(8'h02, r); xb(a[15:8], r); xb(a[7:0], r);
    for (int i = 0; i < n; i++) xb(d[i], r);
    chk(oe_any == 1'b0, "R9 oe during write", oe_any, 0);
    stop();
  endtask

  task automatic rd_mem(input logic [15:0] a, input int n, output logic [7:0] q [8]);
    logic [7:0] r;
    start();
    xb(8'h03, r); xb(a[15:8], r); xb(a[7:0], r);
    chk(oe_any == 1'b0, "R9 oe during address", oe_any, 0);
    for (int i = 0; i < n; i++) begin
      oe_all = 1'b1;
      xb(8'h00, r);
      q[i] = r;
      chk(oe_all == 1'b1, "R9 oe during read data", oe_all, 1);
    end
    stop();
    chk(miso_oe == 1'b0, "R9 oe after release", miso_oe, 0);
  endtask

  task automatic op1(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    start(); xb(a, r); xb(b, r); stop();
  endtask

  initial begin
    logic [7:0] d [8];
    logic [7:0] q [8];
    logic [7:0] r;
    int e0, e1, len;
    logic [10:0] a;
    void'($urandom(32'h5eed_1234));
    wclk(4);
    chk(miso_oe == 1'b0 && !wren && !wrdi && !srw && !wend, "R12 reset outputs",
        {miso_oe, wren, wrdi, srw, wend}, 0);
    rst_n = 1'b1;
    wclk(4);

    e0 = n_wren; e1 = n_wrdi;
    op1(8'h06, 8'h04);
    chk(n_wren == e0 + 1, "R1 wren strobe", n_wren, e0 + 1);
    chk(n_wrdi == e1, "R2 second op ignored", n_wrdi, e1);
    m3 = 1'b1;
    op1(8'h04, 8'h06);
    chk(n_wrdi == e1 + 1, "R1 wrdi strobe mode3", n_wrdi, e1 + 1);
    chk(n_wren == e0 + 1, "R2 wren after wrdi ignored", n_wren, e0 + 1);
    op1(8'hAB, 8'h06);
    chk(n_wren == e0 + 1, "R2 unknown op", n_wren, e0 + 1);

    permit = 1'b1;
    m3 = 1'b0;
    e0 = n_end;
    d[0] = 8'hAA; d[1] = 8'hBB; d[2] = 8'hCC;
    wr_mem(16'hFFFE, 3, d);
    chk(n_end == e0 + 1, "R11 wr_end after write", n_end, e0 + 1);
    m3 = 1'b1;
    rd_mem(16'h07FE, 3, q);
    chk(q[0] == 8'hAA && q[1] == 8'hBB, "R4 read upper bits ignored", {q[0], q[1]}, 16'hAABB);
    chk(q[2] == 8'hCC, "R5 write wraps", q[2], 8'hCC);
    rd_mem(16'h0000, 1, q);
    chk(q[0] == 8'hCC, "R4 wrap addr zero", q[0], 8'hCC);

    m3 = 1'b0;
    d[0] = 8'h11; d[1] = 8'h22;
    wr_mem(16'h000A, 2, d);
    start();
    xb(8'h02, r); xb(8'h00, r); xb(8'h0A, r); xb(8'h77, r);
    r = 8'h00;
    bits(8'hFF, 7, 4, r);
    stop();
    rd_mem(16'h000A, 2, q);
    chk(q[0] == 8'h77, "R5 full byte stored", q[0], 8'h77);
    chk(q[1] == 8'h22, "R5 partial byte dropped", q[1], 8'h22);

    permit = 1'b0;
    e0 = n_end;
    d[0] = 8'h99;
    wr_mem(16'h000B, 1, d);
    rd_mem(16'h000B, 1, q);
    chk(q[0] == 8'h22, "R6 denied write", q[0], 8'h22);
    chk(n_end == e0, "R6 no wr_end when denied", n_end, e0);
    e0 = n_sr;
    op1(8'h01, 8'h3C);
    chk(n_sr == e0, "R6 denied wrsr", n_sr, e0);

    permit = 1'b1;
    m3 = 1'b1;
    e1 = n_end;
    start(); xb(8'h01, r); xb(8'h8E, r); xb(8'h55, r); stop();
    chk(n_sr == e0 + 1 && last_sr == 8'h8E, "R8 wrsr strobe", last_sr, 8'h8E);
    chk(n_end == e1 + 1, "R11 wr_end after wrsr", n_end, e1 + 1);

    stat = 8'hA5;
    start(); xb(8'h05, r);
    oe_all = 1'b1; xb(8'h00, r);
    chk(r == 8'hA5, "R7 rdsr byte", r, 8'hA5);
    xb(8'h00, r);
    chk(r == 8'hA5, "R7 rdsr repeat", r, 8'hA5);
    chk(oe_all == 1'b1, "R9 oe in rdsr", oe_all, 1);
    stop();
    m3 = 1'b0;
    stat = 8'h5A;
    start(); xb(8'h05, r); xb(8'h00, r); stop();
    chk(r == 8'h5A, "R3 rdsr mode0", r, 8'h5A);

    start();
    xb(8'h02, r); xb(8'h00, r); xb(8'h40, r);
    r = 8'h00;
    bits(8'h9C, 7, 4, r);
    pause();
    bits(8'h9C, 3, 0, r);
    stop();
    rd_mem(16'h0040, 1, q);
    chk(q[0] == 8'h9C, "R10 hold in write", q[0], 8'h9C);
    m3 = 1'b1;
    start();
    xb(8'h03, r); xb(8'h00, r); xb(8'h40, r);
    r = 8'h00;
    bits(8'h00, 7, 4, r);
    pause();
    bits(8'h00, 3, 0, r);
    stop();
    chk(r == 8'h9C, "R10 hold in read", r, 8'h9C);

    for (int it = 0; it < 40; it++) begin
      a = 11'($urandom);
      len = 1 + int'($urandom % 4);
      for (int k = 0; k < len; k++) begin
        d[k] = 8'($urandom);
        model[11'(a + 11'(k))] = d[k];
      end
      m3 = 1'($urandom);
      wr_mem({5'($urandom), a}, len, d);
      m3 = ~m3;
      rd_mem({5'($urandom), a}, len, q);
      for (int k = 0; k < len; k++)
        chk(q[k] == model[11'(a + 11'(k))], "R3 R4 R5 random readback", q[k],
            model[11'(a + 11'(k))]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule